// File: doc/BRIEF.md
# Character-Based Software Flow Control Engine

This block handles in-band pause and resume for one serial channel. A 4-bit mode field picks what the block sends and what it listens for. The block stores four programmable characters: two "resume" characters and two "pause" characters. It watches the stream of received bytes for these characters and raises a pause flag that tells the local transmitter to hold off. When the surrounding logic asks it to pause or resume the far end, it hands one or two characters to the local transmitter through a valid/ready handshake.

Both the transmit and the receive side can work with a single character or with a pair of characters. A pair is always the first character of a kind followed by the second one. How the receive bits are read depends on the transmit bits. With receive select 11, the block accepts either character on its own when the transmit side uses one character. It requires the full pair, received back to back, when the transmit side uses two characters or none.

Baud timing, serialisation and buffering are handled elsewhere. This block only looks at whole bytes and produces whole bytes.

Top module: `swfc_engine`

## Requirements
- R1: After a synchronous reset the mode is 0000 and all four characters are 0x00. `tx_paused` is 0, `inj_valid` is 0 and `send_ready` is 1.
- R2: Mode bits [3:2] select what is sent. 00 sends nothing. 10 sends resume-1 or pause-1. 01 sends resume-2 or pause-2. `send_xoff`=1 asks for the pause kind and 0 asks for the resume kind.
- R3: When mode bits [3:2] are 11, one request produces two characters: character 1 of the requested kind, then character 2. `inj_data` and `inj_valid` hold steady while `inj_ready` is low. The second byte is offered in the cycle right after the first byte is accepted.
- R4: A request is taken only when `send_ready` is 1 and mode bits [3:2] are not 00. A request made while a sequence is in progress, or while bits [3:2] are 00, is dropped with no effect.
- R5: Mode bits [1:0] = 10 compares received bytes against resume-1 and pause-1. Bits [1:0] = 01 compares against resume-2 and pause-2.
- R6: With bits [1:0] = 11 and bits [3:2] = 10 or 01, either pause character on its own counts as a pause, and either resume character on its own counts as a resume.
- R7: With bits [1:0] = 11 and bits [3:2] = 11 or 00, the block acts only on pause-1 directly followed by pause-2, or resume-1 directly followed by resume-2. A byte that breaks a partial match cancels it, and that byte is then checked again as a possible first character.
- R8: A detected pause sets `tx_paused` one clock after the byte strobe. A detected resume clears it. If a byte matches both a pause and a resume character, pause wins. While bits [1:0] are 00, `tx_paused` is 0.
- R9: Every mode write returns the engine to idle: `tx_paused` is cleared, any partial receive match is dropped, and any sequence still being sent is abandoned.
- R10: `char_sel` selects the character that `char_wr` writes: 0 is resume-1, 1 is resume-2, 2 is pause-1 and 3 is pause-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that loads `mode_in` |
| mode_in | input | 4 | New mode: [3:2] transmit select, [1:0] receive select |
| char_wr | input | 1 | Strobe that writes a flow-control character |
| char_sel | input | 2 | Character index (0 resume-1, 1 resume-2, 2 pause-1, 3 pause-2) |
| char_in | input | 8 | Character value to write |
| rx_valid | input | 1 | Strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| send_req | input | 1 | Request to send a pause or resume sequence |
| send_xoff | input | 1 | Kind of request: 1 pause, 0 resume |
| inj_ready | input | 1 | Transmitter accepts the byte offered this cycle |
| inj_valid | output | 1 | A flow-control byte is being offered |
| inj_data | output | 8 | Offered flow-control byte |
| send_ready | output | 1 | Engine is idle and can take a request |
| tx_paused | output | 1 | The far end has asked this side to stop sending |

## Verification
The receive side is swept over all sixteen mode values. Every sweep uses the same byte stream, which contains lone characters, complete pairs, pairs broken by a stray byte, and a first character repeated before its partner. This stream separates single matching on one character set, either-character matching, and strict pair matching with re-checking of the breaking byte. The transmit side is tried with every transmit select, both request kinds, and ready patterns with and without stalls. These runs show the character choice, the order of a pair, and that data stays steady under backpressure. Further targeted stimuli cover a request made while a sequence is busy, a mode write in the middle of a pair or a sequence, and a byte that matches both a pause and a resume character.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int NUM_CHARS = 4;
  localparam int IDX_ON1   = 0;
  localparam int IDX_ON2   = 1;
  localparam int IDX_OFF1  = 2;
  localparam int IDX_OFF2  = 3;

  typedef enum logic [1:0] {
    TXS_IDLE   = 2'd0,
    TXS_FIRST  = 2'd1,
    TXS_SECOND = 2'd2
  } tx_state_t;

  typedef enum logic [1:0] {
    SQ_NONE = 2'd0,
    SQ_ON1  = 2'd1,
    SQ_OFF1 = 2'd2
  } seq_state_t;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [1:0]        rx_sel,
  input  logic [1:0]        tx_sel,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic [CHAR_W-1:0] on1_i,
  input  logic [CHAR_W-1:0] on2_i,
  input  logic [CHAR_W-1:0] off1_i,
  input  logic [CHAR_W-1:0] off2_i,
  output logic              tx_paused
);
  seq_state_t sq_q;
  logic       seq_mode;
  logic       hit_on;
  logic       hit_off;

  assign seq_mode = (rx_sel == 2'b11) && ((tx_sel == 2'b11) || (tx_sel == 2'b00));

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    case (rx_sel)
      2'b10: begin
        hit_on  = (rx_byte == on1_i);
        hit_off = (rx_byte == off1_i);
      end
      2'b01: begin
        hit_on  = (rx_byte == on2_i);
        hit_off = (rx_byte == off2_i);
      end
      2'b11: begin
        hit_on  = (rx_byte == on1_i) || (rx_byte == on2_i);
        hit_off = (rx_byte == off1_i) || (rx_byte == off2_i);
      end
      default: begin
        hit_on  = 1'b0;
        hit_off = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear || (rx_sel == 2'b00)) begin
      tx_paused <= 1'b0;
      sq_q      <= SQ_NONE;
    end else if (rx_valid) begin
      if (seq_mode) begin
        if ((sq_q == SQ_OFF1) && (rx_byte == off2_i)) begin
          tx_paused <= 1'b1;
          sq_q      <= SQ_NONE;
        end else if ((sq_q == SQ_ON1) && (rx_byte == on2_i)) begin
          tx_paused <= 1'b0;
          sq_q      <= SQ_NONE;
        end else if (rx_byte == off1_i) begin
          sq_q <= SQ_OFF1;
        end else if (rx_byte == on1_i) begin
          sq_q <= SQ_ON1;
        end else begin
          sq_q <= SQ_NONE;
        end
      end else begin
        sq_q <= SQ_NONE;
        if (hit_off)     tx_paused <= 1'b1;
        else if (hit_on) tx_paused <= 1'b0;
      end
    end
  end

  // R8
  rise_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_paused) |-> $past(rx_valid));

  // R7
  seq_pause_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_paused) && $past(seq_mode)) |-> ($past(rx_byte) == $past(off2_i)));

  // R8
  rx_off_unpaused_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_sel == 2'b00) |-> !tx_paused);
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [1:0]        tx_sel,
  input  logic              send_req,
  input  logic              send_xoff,
  input  logic [CHAR_W-1:0] on1_i,
  input  logic [CHAR_W-1:0] on2_i,
  input  logic [CHAR_W-1:0] off1_i,
  input  logic [CHAR_W-1:0] off2_i,
  input  logic              inj_ready,
  output logic              inj_valid,
  output logic [CHAR_W-1:0] inj_data,
  output logic              send_ready
);
  tx_state_t st_q;
  logic      kind_q;
  logic      dual_q;
  logic      accept;

  assign accept     = (st_q == TXS_IDLE) && send_req && (tx_sel != 2'b00);
  assign inj_valid  = (st_q != TXS_IDLE);
  assign send_ready = (st_q == TXS_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st_q     <= TXS_IDLE;
      inj_data <= '0;
      kind_q   <= 1'b0;
      dual_q   <= 1'b0;
    end else begin
      case (st_q)
        TXS_IDLE: begin
          if (accept) begin
            st_q     <= TXS_FIRST;
            kind_q   <= send_xoff;
            dual_q   <= (tx_sel == 2'b11);
            if (tx_sel == 2'b01) inj_data <= send_xoff ? off2_i : on2_i;
            else                 inj_data <= send_xoff ? off1_i : on1_i;
          end
        end
        TXS_FIRST: begin
          if (inj_ready) begin
            if (dual_q) begin
              st_q     <= TXS_SECOND;
              inj_data <= kind_q ? off2_i : on2_i;
            end else begin
              st_q <= TXS_IDLE;
            end
          end
        end
        TXS_SECOND: begin
          if (inj_ready) st_q <= TXS_IDLE;
        end
        default: st_q <= TXS_IDLE;
      endcase
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_valid && !inj_ready && !clear) |=> (inj_valid && $stable(inj_data)));

  // R3
  pair_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == TXS_FIRST) && dual_q && inj_ready && !clear) |=> inj_valid);

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_valid && send_req && !inj_ready && !clear) |=> $stable(inj_data));
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              char_wr,
  input  logic [1:0]        char_sel,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              send_req,
  input  logic              send_xoff,
  input  logic              inj_ready,
  output logic              inj_valid,
  output logic [CHAR_W-1:0] inj_data,
  output logic              send_ready,
  output logic              tx_paused
);
  localparam int HALF = MODE_W / 2;

  logic [MODE_W-1:0] mode_q;
  logic [CHAR_W-1:0] char_q [NUM_CHARS];
  logic [1:0]        tx_sel;
  logic [1:0]        rx_sel;

  assign tx_sel = mode_q[MODE_W-1:HALF];
  assign rx_sel = mode_q[HALF-1:0];

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_in;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CHARS; i++) begin
      if (rst) char_q[i] <= '0;
      else if (char_wr && (char_sel == 2'(i))) char_q[i] <= char_in;
    end
  end

  swfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .clear     (mode_wr),
    .rx_sel    (rx_sel),
    .tx_sel    (tx_sel),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .on1_i     (char_q[IDX_ON1]),
    .on2_i     (char_q[IDX_ON2]),
    .off1_i    (char_q[IDX_OFF1]),
    .off2_i    (char_q[IDX_OFF2]),
    .tx_paused (tx_paused)
  );

  swfc_tx_inject #(.CHAR_W(CHAR_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .clear      (mode_wr),
    .tx_sel     (tx_sel),
    .send_req   (send_req),
    .send_xoff  (send_xoff),
    .on1_i      (char_q[IDX_ON1]),
    .on2_i      (char_q[IDX_ON2]),
    .off1_i     (char_q[IDX_OFF1]),
    .off2_i     (char_q[IDX_OFF2]),
    .inj_ready  (inj_ready),
    .inj_valid  (inj_valid),
    .inj_data   (inj_data),
    .send_ready (send_ready)
  );

  // R4
  tx_none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_sel == 2'b00) |-> !inj_valid);

  // R9
  mode_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode_wr) |-> (!tx_paused && !inj_valid));
endmodule

// File: tb/swfc_engine_bench.sv
module swfc_engine_bench;
  localparam logic [7:0] ON1  = 8'h11;
  localparam logic [7:0] ON2  = 8'h12;
  localparam logic [7:0] OFF1 = 8'h13;
  localparam logic [7:0] OFF2 = 8'h14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [3:0] mode_in = '0;
  logic       char_wr = 1'b0;
  logic [1:0] char_sel = '0;
  logic [7:0] char_in = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       send_req = 1'b0;
  logic       send_xoff = 1'b0;
  logic       inj_ready = 1'b0;
  logic       inj_valid;
  logic [7:0] inj_data;
  logic       send_ready;
  logic       tx_paused;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  swfc_engine u_swfc_engine (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
    .char_wr(char_wr), .char_sel(char_sel), .char_in(char_in),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .send_req(send_req),
    .send_xoff(send_xoff), .inj_ready(inj_ready), .inj_valid(inj_valid),
    .inj_data(inj_data), .send_ready(send_ready), .tx_paused(tx_paused)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_in = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic write_char(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); char_wr = 1'b1; char_sel = s; char_in = v;
    @(negedge clk); char_wr = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // Bench reference: sq 0 none, 1 got resume-1, 2 got pause-1
  function automatic void model_rx(input logic [3:0] m, input logic [7:0] b,
                                   inout logic p, inout int sq);
    logic [1:0] rs = m[1:0];
    logic [1:0] ts = m[3:2];
    if (rs == 2'b00) begin p = 1'b0; sq = 0; return; end
    if (rs == 2'b11 && (ts == 2'b11 || ts == 2'b00)) begin
      if (sq == 2 && b == OFF2) begin p = 1'b1; sq = 0; end
      else if (sq == 1 && b == ON2) begin p = 1'b0; sq = 0; end
      else if (b == OFF1) sq = 2;
      else if (b == ON1) sq = 1;
      else sq = 0;
    end else begin
      logic off_m, on_m;
      off_m = (rs[1] && b == OFF1) || (rs[0] && b == OFF2);
      on_m  = (rs[1] && b == ON1)  || (rs[0] && b == ON2);
      if (off_m) p = 1'b1;
      else if (on_m) p = 1'b0;
      sq = 0;
    end
  endfunction

  task automatic tx_run(input logic xoff, input int stall, output int n,
                        output logic [7:0] b0, output logic [7:0] b1);
    n = 0; b0 = '0; b1 = '0;
    @(negedge clk); send_req = 1'b1; send_xoff = xoff;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); send_req = 1'b0;
      inj_ready = ((k % (stall + 1)) == stall);
      if (inj_valid && inj_ready) begin
        if (n == 0) b0 = inj_data; else b1 = inj_data;
        n++;
      end
    end
    inj_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [7:0] stream [16];

  initial begin
    int n;
    logic [7:0] b0, b1;
    stream = '{OFF1, OFF2, ON1, ON2, ON1, OFF1, OFF2, 8'h55,
               ON2, ON1, 8'h55, ON2, OFF2, ON1, ON1, ON2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 paused", tx_paused, 0);
    check("R1 inj_valid", inj_valid, 0);
    check("R1 send_ready", send_ready, 1);
    // R1: mode 0000 after reset -> request dropped
    tx_run(1'b1, 0, n, b0, b1);
    check("R1 no send in reset mode", n, 0);

    // R10 program characters by index
    write_char(2'd0, ON1);
    write_char(2'd1, ON2);
    write_char(2'd2, OFF1);
    write_char(2'd3, OFF2);

    // R5 R6 R7 R8: sweep all modes on the receive side
    for (int m = 0; m < 16; m++) begin
      logic p; int sq;
      p = 1'b0; sq = 0;
      write_mode(4'(m));
      for (int i = 0; i < 16; i++) begin
        rx_send(stream[i]);
        model_rx(4'(m), stream[i], p, sq);
        check($sformatf("R5/R6/R7/R8 mode %0h byte %0d", m, i), tx_paused, p);
      end
    end

    // R2 R3 R10: transmit select and kind sweep with and without stalls
    for (int ts = 1; ts < 4; ts++) begin
      for (int kd = 0; kd < 2; kd++) begin
        for (int st = 0; st < 3; st += 2) begin
          logic [7:0] e0, e1;
          write_mode(4'(ts << 2));
          e0 = (ts == 1) ? (kd ? OFF2 : ON2) : (kd ? OFF1 : ON1);
          e1 = kd ? OFF2 : ON2;
          tx_run(kd[0], st, n, b0, b1);
          check($sformatf("R2/R3 count ts%0d kd%0d", ts, kd), n, (ts == 3) ? 2 : 1);
          check($sformatf("R2/R10 first byte ts%0d kd%0d", ts, kd), b0, e0);
          if (ts == 3) check($sformatf("R3 second byte kd%0d", kd), b1, e1);
        end
      end
    end

    // R4: request while busy is dropped
    write_mode(4'b1100);
    @(negedge clk); send_req = 1'b1; send_xoff = 1'b0;
    @(negedge clk); send_req = 1'b1; send_xoff = 1'b1;
    check("R4 busy send_ready", send_ready, 0);
    check("R4 busy data", inj_data, ON1);
    @(negedge clk); send_req = 1'b0;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      inj_ready = 1'b1;
      if (inj_valid) begin
        if (n == 1) check("R4 second of first request", inj_data, ON2);
        n++;
      end
      @(negedge clk);
    end
    inj_ready = 1'b0;
    check("R4 busy request dropped", n, 2);
    check("R4 back to idle", send_ready, 1);

    // R9: mode write abandons a stalled sequence
    write_mode(4'b1100);
    @(negedge clk); send_req = 1'b1; send_xoff = 1'b1;
    @(negedge clk); send_req = 1'b0;
    check("R9 sequence started", inj_valid, 1);
    write_mode(4'b1100);
    check("R9 sequence abandoned", inj_valid, 0);

    // R9: mode write drops a partial receive match
    write_mode(4'b0011);
    rx_send(OFF1);
    write_mode(4'b0011);
    rx_send(OFF2);
    check("R9 partial match dropped", tx_paused, 0);

    // R9: mode write clears pause
    write_mode(4'b1010);
    rx_send(OFF1);
    check("R8 pause set", tx_paused, 1);
    write_mode(4'b0110);
    check("R9 pause cleared by mode write", tx_paused, 0);

    // R8: pause wins when a byte matches both kinds
    write_char(2'd0, OFF1);
    write_mode(4'b1010);
    rx_send(OFF1);
    check("R8 pause priority", tx_paused, 1);

    // R8: receive select 00 forces unpaused
    write_mode(4'b1000);
    rx_send(OFF1);
    check("R8 rx none unpaused", tx_paused, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule